// File: doc/BRIEF.md
# HDLC Test and Loopback Controller

This block holds the test control register of an HDLC controller and the steering logic that the register drives. A host writes one 8-bit control word. From it the block produces a sticky soft reset for the framing engines, two plain test-mode outputs, and three routing modes. The routing modes can copy received bytes into the transmit FIFO, swap the host's FIFO accesses between the two FIFOs, and turn the serial transmit stream back into the receiver.

The soft reset stays set after the host writes a zero to its bit. It clears only when the host makes a run of consecutive control writes with that bit at zero, two by default. Any write with the bit at one restarts the run. The routing is purely combinational. The only state in the block is the register and the zero-write count.

Each FIFO entry carries a 2-bit tag. Bit 0 marks end of packet and bit 1 marks a bad or aborted packet. The block passes tags through unchanged and never interprets them.

Top module: `hdlc_testloop_ctrl`

## Requirements
- R1: After hardware reset, `cfg_rdata` reads 0x00, and `soft_rst`, `crc_test_mode` and `addr_test_mode` are low.
- R2: A control write with bit 7 set drives `soft_rst` high from the cycle after the write, and `cfg_rdata[7]` reads 1.
- R3: Once `soft_rst` is set, one write with bit 7 clear leaves it set. A second consecutive such write clears it from the following cycle.
- R4: A write with bit 7 set that falls between zero writes restarts the zero-write count. Two further zero writes are then needed to clear `soft_rst`.
- R5: `cfg_rdata[5:4]` always reads 0, whatever value was written to those bits.
- R6: Written bit 3 drives `crc_test_mode` and written bit 1 drives `addr_test_mode`. Both are readable at the same positions of `cfg_rdata`.
- R7: When bit 6 (receive-to-transmit loopback) is set and bit 2 is clear, a valid receive byte is written to both FIFOs with the same data and tag, for any tag value. When bit 6 is clear, the byte goes only to the receive FIFO.
- R8: Outside FIFO test, a host transmit write reaches the transmit FIFO. A looped receive byte in the same cycle takes the transmit FIFO port, and the host byte is dropped.
- R9: When bit 2 (FIFO test) is set, a host transmit write goes to the receive FIFO with its data and tag and does not reach the transmit FIFO. The receive path then has no access to the receive FIFO.
- R10: A host receive read normally strobes `rxf_rd` and returns the receive FIFO data and tag. With bit 2 set, it strobes `txf_rd` instead and returns the transmit FIFO data and tag. The two read strobes are never high together.
- R11: `rx_ser` equals `tx_ser` only when bit 0 (transmit-to-receive loopback), `rx_en` and `tx_en` are all set. Otherwise `rx_ser` equals `rx_line`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control write data |
| cfg_rdata | output | 8 | Control register readback |
| soft_rst | output | 1 | Sticky soft reset for the HDLC engines |
| crc_test_mode | output | 1 | CRC remainder test mode (bit 3) |
| addr_test_mode | output | 1 | Address recognition test mode (bit 1) |
| rxp_valid | input | 1 | Receive path byte valid |
| rxp_data | input | DATA_W | Receive path byte |
| rxp_tag | input | TAG_W | Receive path tag |
| hst_txf_wr | input | 1 | Host write aimed at the transmit FIFO |
| hst_txf_data | input | DATA_W | Host write data |
| hst_txf_tag | input | TAG_W | Host write tag |
| hst_rxf_rd | input | 1 | Host read aimed at the receive FIFO |
| hst_rd_data | output | DATA_W | Data returned to the host |
| hst_rd_tag | output | TAG_W | Tag returned to the host |
| txf_wr | output | 1 | Transmit FIFO write |
| txf_wdata | output | DATA_W | Transmit FIFO write data |
| txf_wtag | output | TAG_W | Transmit FIFO write tag |
| txf_rd | output | 1 | Transmit FIFO read |
| txf_rdata | input | DATA_W | Transmit FIFO head data |
| txf_rtag | input | TAG_W | Transmit FIFO head tag |
| rxf_wr | output | 1 | Receive FIFO write |
| rxf_wdata | output | DATA_W | Receive FIFO write data |
| rxf_wtag | output | TAG_W | Receive FIFO write tag |
| rxf_rd | output | 1 | Receive FIFO read |
| rxf_rdata | input | DATA_W | Receive FIFO head data |
| rxf_rtag | input | TAG_W | Receive FIFO head tag |
| rx_en | input | 1 | Receiver enabled |
| tx_en | input | 1 | Transmitter enabled |
| tx_ser | input | 1 | Serial transmit stream from the framer |
| rx_line | input | 1 | Serial receive line |
| rx_ser | output | 1 | Serial stream fed to the receiver |

## Verification
The bench targets the soft-reset clear sequence. A design that cleared on the first zero write, or that kept its count across an intervening one-write, would drop `soft_rst` one write too early. It also drives a host transmit write in the same cycle as a looped receive byte, and a receive byte in the same cycle as a FIFO-test host write. A wrong priority there shows up as the wrong payload at a FIFO port, or as a write to the wrong FIFO. A design that ignored either enable would loop the serial stream when it should not, and a design that stored bits 5 and 4 would expose them on readback.

// File: rtl/hdlc_tl_pkg.sv
package hdlc_tl_pkg;

    localparam int CTRL_W      = 8;
    localparam int BIT_SRST    = 7;
    localparam int BIT_RTLOOP  = 6;
    localparam int BIT_CRCTEST = 3;
    localparam int BIT_FIFOTST = 2;
    localparam int BIT_ADRTEST = 1;
    localparam int BIT_TRLOOP  = 0;

    typedef struct packed {
        logic srst;
        logic rt_loop;
        logic crc_test;
        logic fifo_test;
        logic addr_test;
        logic tr_loop;
    } ctrl_t;

    function automatic logic [CTRL_W-1:0] pack_ctrl(ctrl_t c);
        logic [CTRL_W-1:0] v;
        v              = '0;
        v[BIT_SRST]    = c.srst;
        v[BIT_RTLOOP]  = c.rt_loop;
        v[BIT_CRCTEST] = c.crc_test;
        v[BIT_FIFOTST] = c.fifo_test;
        v[BIT_ADRTEST] = c.addr_test;
        v[BIT_TRLOOP]  = c.tr_loop;
        return v;
    endfunction

endpackage

// File: rtl/hdlc_tl_regfile.sv
module hdlc_tl_regfile
    import hdlc_tl_pkg::*;
#(
    parameter int CLEAR_WRITES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [CTRL_W-1:0] wdata,
    output ctrl_t             ctrl,
    output logic [CTRL_W-1:0] rdata
);

    localparam int CNT_W = (CLEAR_WRITES > 1) ? $clog2(CLEAR_WRITES) : 1;
    localparam logic [CNT_W-1:0] LAST_ZERO = CNT_W'(CLEAR_WRITES - 1);

    typedef struct packed {
        ctrl_t            ctrl;
        logic [CNT_W-1:0] zcnt;
    } state_t;

    state_t st_d, st_q;
    logic   unused_rsvd;

    // bits 5:4 are reserved and never stored
    assign unused_rsvd = ^wdata[5:4];

    always_comb begin
        st_d = st_q;
        if (wr) begin
            st_d.ctrl.rt_loop   = wdata[BIT_RTLOOP];
            st_d.ctrl.crc_test  = wdata[BIT_CRCTEST];
            st_d.ctrl.fifo_test = wdata[BIT_FIFOTST];
            st_d.ctrl.addr_test = wdata[BIT_ADRTEST];
            st_d.ctrl.tr_loop   = wdata[BIT_TRLOOP];
            if (wdata[BIT_SRST]) begin
                // a one write (re)arms the reset and restarts the zero run
                st_d.ctrl.srst = 1'b1;
                st_d.zcnt      = '0;
            end else if (st_q.ctrl.srst) begin
                if (st_q.zcnt == LAST_ZERO) begin
                    st_d.ctrl.srst = 1'b0;
                    st_d.zcnt      = '0;
                end else begin
                    st_d.zcnt = st_q.zcnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl  = st_q.ctrl;
    assign rdata = pack_ctrl(st_q.ctrl);

endmodule

// File: rtl/hdlc_tl_router.sv
module hdlc_tl_router #(
    parameter int DATA_W = 8,
    parameter int TAG_W  = 2
) (
    input  logic              rt_loop,
    input  logic              fifo_test,
    input  logic              rxp_valid,
    input  logic [DATA_W-1:0] rxp_data,
    input  logic [TAG_W-1:0]  rxp_tag,
    input  logic              hst_txf_wr,
    input  logic [DATA_W-1:0] hst_txf_data,
    input  logic [TAG_W-1:0]  hst_txf_tag,
    input  logic              hst_rxf_rd,
    output logic [DATA_W-1:0] hst_rd_data,
    output logic [TAG_W-1:0]  hst_rd_tag,
    output logic              txf_wr,
    output logic [DATA_W-1:0] txf_wdata,
    output logic [TAG_W-1:0]  txf_wtag,
    output logic              txf_rd,
    input  logic [DATA_W-1:0] txf_rdata,
    input  logic [TAG_W-1:0]  txf_rtag,
    output logic              rxf_wr,
    output logic [DATA_W-1:0] rxf_wdata,
    output logic [TAG_W-1:0]  rxf_wtag,
    output logic              rxf_rd,
    input  logic [DATA_W-1:0] rxf_rdata,
    input  logic [TAG_W-1:0]  rxf_rtag
);

    localparam int PAY_W = DATA_W + TAG_W;

    logic             loop_hit;
    logic [PAY_W-1:0] rx_pay, host_pay, txf_pay, rxf_pay, rd_pay;

    assign loop_hit = rt_loop & rxp_valid;
    assign rx_pay   = {rxp_data, rxp_tag};
    assign host_pay = {hst_txf_data, hst_txf_tag};

    always_comb begin
        // transmit FIFO write port: looped receive byte beats the host
        txf_wr  = loop_hit | (hst_txf_wr & ~fifo_test);
        txf_pay = loop_hit ? rx_pay : host_pay;
        // receive FIFO write port: host owns it during FIFO test
        rxf_wr  = fifo_test ? hst_txf_wr : rxp_valid;
        rxf_pay = fifo_test ? host_pay : rx_pay;
        // host read swap
        txf_rd  = hst_rxf_rd & fifo_test;
        rxf_rd  = hst_rxf_rd & ~fifo_test;
        rd_pay  = fifo_test ? {txf_rdata, txf_rtag} : {rxf_rdata, rxf_rtag};
    end

    assign {txf_wdata, txf_wtag}     = txf_pay;
    assign {rxf_wdata, rxf_wtag}     = rxf_pay;
    assign {hst_rd_data, hst_rd_tag} = rd_pay;

endmodule

// File: rtl/hdlc_tl_serloop.sv
module hdlc_tl_serloop (
    input  logic tr_loop,
    input  logic rx_en,
    input  logic tx_en,
    input  logic tx_ser,
    input  logic rx_line,
    output logic rx_ser
);

    logic loop_on;

    assign loop_on = tr_loop & rx_en & tx_en;
    assign rx_ser  = loop_on ? tx_ser : rx_line;

endmodule

// File: rtl/hdlc_testloop_ctrl.sv
module hdlc_testloop_ctrl
    import hdlc_tl_pkg::*;
#(
    parameter int DATA_W       = 8,
    parameter int TAG_W        = 2,
    parameter int CLEAR_WRITES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    output logic              soft_rst,
    output logic              crc_test_mode,
    output logic              addr_test_mode,
    input  logic              rxp_valid,
    input  logic [DATA_W-1:0] rxp_data,
    input  logic [TAG_W-1:0]  rxp_tag,
    input  logic              hst_txf_wr,
    input  logic [DATA_W-1:0] hst_txf_data,
    input  logic [TAG_W-1:0]  hst_txf_tag,
    input  logic              hst_rxf_rd,
    output logic [DATA_W-1:0] hst_rd_data,
    output logic [TAG_W-1:0]  hst_rd_tag,
    output logic              txf_wr,
    output logic [DATA_W-1:0] txf_wdata,
    output logic [TAG_W-1:0]  txf_wtag,
    output logic              txf_rd,
    input  logic [DATA_W-1:0] txf_rdata,
    input  logic [TAG_W-1:0]  txf_rtag,
    output logic              rxf_wr,
    output logic [DATA_W-1:0] rxf_wdata,
    output logic [TAG_W-1:0]  rxf_wtag,
    output logic              rxf_rd,
    input  logic [DATA_W-1:0] rxf_rdata,
    input  logic [TAG_W-1:0]  rxf_rtag,
    input  logic              rx_en,
    input  logic              tx_en,
    input  logic              tx_ser,
    input  logic              rx_line,
    output logic              rx_ser
);

    ctrl_t ctrl;

    hdlc_tl_regfile #(
        .CLEAR_WRITES(CLEAR_WRITES)
    ) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (cfg_wr),
        .wdata (cfg_wdata),
        .ctrl  (ctrl),
        .rdata (cfg_rdata)
    );

    assign soft_rst       = ctrl.srst;
    assign crc_test_mode  = ctrl.crc_test;
    assign addr_test_mode = ctrl.addr_test;

    hdlc_tl_router #(
        .DATA_W(DATA_W),
        .TAG_W (TAG_W)
    ) u_route (
        .rt_loop      (ctrl.rt_loop),
        .fifo_test    (ctrl.fifo_test),
        .rxp_valid    (rxp_valid),
        .rxp_data     (rxp_data),
        .rxp_tag      (rxp_tag),
        .hst_txf_wr   (hst_txf_wr),
        .hst_txf_data (hst_txf_data),
        .hst_txf_tag  (hst_txf_tag),
        .hst_rxf_rd   (hst_rxf_rd),
        .hst_rd_data  (hst_rd_data),
        .hst_rd_tag   (hst_rd_tag),
        .txf_wr       (txf_wr),
        .txf_wdata    (txf_wdata),
        .txf_wtag     (txf_wtag),
        .txf_rd       (txf_rd),
        .txf_rdata    (txf_rdata),
        .txf_rtag     (txf_rtag),
        .rxf_wr       (rxf_wr),
        .rxf_wdata    (rxf_wdata),
        .rxf_wtag     (rxf_wtag),
        .rxf_rd       (rxf_rd),
        .rxf_rdata    (rxf_rdata),
        .rxf_rtag     (rxf_rtag)
    );

    hdlc_tl_serloop u_ser (
        .tr_loop (ctrl.tr_loop),
        .rx_en   (rx_en),
        .tx_en   (tx_en),
        .tx_ser  (tx_ser),
        .rx_line (rx_line),
        .rx_ser  (rx_ser)
    );

endmodule

// File: rtl/hdlc_tl_checker.sv
module hdlc_tl_checker #(
    parameter int DATA_W = 8,
    parameter int TAG_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr,
    input logic [7:0]        cfg_wdata,
    input logic [7:0]        cfg_rdata,
    input logic              soft_rst,
    input logic              crc_test_mode,
    input logic              addr_test_mode,
    input logic              rxp_valid,
    input logic              hst_rxf_rd,
    input logic              txf_wr,
    input logic [DATA_W-1:0] txf_wdata,
    input logic [TAG_W-1:0]  txf_wtag,
    input logic              txf_rd,
    input logic              rxf_wr,
    input logic [DATA_W-1:0] rxf_wdata,
    input logic [TAG_W-1:0]  rxf_wtag,
    input logic              rxf_rd,
    input logic              rx_en,
    input logic              tx_en,
    input logic              rx_ser,
    input logic              rx_line
);

    assert_srst_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_wdata[7]) |=> soft_rst);

    assert_srst_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(soft_rst) |-> $past(cfg_wr && !cfg_wdata[7]));

    assert_rsvd_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[5:4] == 2'b00);

    assert_mode_mirror_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (crc_test_mode == cfg_rdata[3]) && (addr_test_mode == cfg_rdata[1]));

    assert_rt_dual_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[6] && !cfg_rdata[2] && rxp_valid)
        |-> (txf_wr && rxf_wr && txf_wdata == rxf_wdata && txf_wtag == rxf_wtag));

    assert_ftst_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[2] && hst_rxf_rd) |-> (txf_rd && !rxf_rd));

    assert_read_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(txf_rd && rxf_rd));

    assert_ser_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_en && tx_en && cfg_rdata[0]) |-> (rx_ser == rx_line));

endmodule

bind hdlc_testloop_ctrl hdlc_tl_checker #(
    .DATA_W(DATA_W),
    .TAG_W (TAG_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_wr         (cfg_wr),
    .cfg_wdata      (cfg_wdata),
    .cfg_rdata      (cfg_rdata),
    .soft_rst       (soft_rst),
    .crc_test_mode  (crc_test_mode),
    .addr_test_mode (addr_test_mode),
    .rxp_valid      (rxp_valid),
    .hst_rxf_rd     (hst_rxf_rd),
    .txf_wr         (txf_wr),
    .txf_wdata      (txf_wdata),
    .txf_wtag       (txf_wtag),
    .txf_rd         (txf_rd),
    .rxf_wr         (rxf_wr),
    .rxf_wdata      (rxf_wdata),
    .rxf_wtag       (rxf_wtag),
    .rxf_rd         (rxf_rd),
    .rx_en          (rx_en),
    .tx_en          (tx_en),
    .rx_ser         (rx_ser),
    .rx_line        (rx_line)
);

// File: tb/tb_hdlc_testloop_ctrl.sv
module tb_hdlc_testloop_ctrl;

    localparam int DW = 8;
    localparam int TW = 2;

    localparam int OB_RDATA   = 0;
    localparam int OB_SRST    = 1;
    localparam int OB_CRC     = 2;
    localparam int OB_ADDR    = 3;
    localparam int OB_TXF_WR  = 4;
    localparam int OB_TXF_PAY = 5;
    localparam int OB_RXF_WR  = 6;
    localparam int OB_RXF_PAY = 7;
    localparam int OB_RD_SEL  = 8;
    localparam int OB_RD_PAY  = 9;
    localparam int OB_RXSER   = 10;

    logic          clk, rst_n;
    logic          cfg_wr;
    logic [7:0]    cfg_wdata, cfg_rdata;
    logic          soft_rst, crc_test_mode, addr_test_mode;
    logic          rxp_valid;
    logic [DW-1:0] rxp_data;
    logic [TW-1:0] rxp_tag;
    logic          hst_txf_wr;
    logic [DW-1:0] hst_txf_data;
    logic [TW-1:0] hst_txf_tag;
    logic          hst_rxf_rd;
    logic [DW-1:0] hst_rd_data;
    logic [TW-1:0] hst_rd_tag;
    logic          txf_wr, txf_rd, rxf_wr, rxf_rd;
    logic [DW-1:0] txf_wdata, txf_rdata, rxf_wdata, rxf_rdata;
    logic [TW-1:0] txf_wtag, txf_rtag, rxf_wtag, rxf_rtag;
    logic          rx_en, tx_en, tx_ser, rx_line, rx_ser;

    hdlc_testloop_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .soft_rst(soft_rst),
        .crc_test_mode(crc_test_mode), .addr_test_mode(addr_test_mode),
        .rxp_valid(rxp_valid), .rxp_data(rxp_data), .rxp_tag(rxp_tag),
        .hst_txf_wr(hst_txf_wr), .hst_txf_data(hst_txf_data),
        .hst_txf_tag(hst_txf_tag), .hst_rxf_rd(hst_rxf_rd),
        .hst_rd_data(hst_rd_data), .hst_rd_tag(hst_rd_tag),
        .txf_wr(txf_wr), .txf_wdata(txf_wdata), .txf_wtag(txf_wtag),
        .txf_rd(txf_rd), .txf_rdata(txf_rdata), .txf_rtag(txf_rtag),
        .rxf_wr(rxf_wr), .rxf_wdata(rxf_wdata), .rxf_wtag(rxf_wtag),
        .rxf_rd(rxf_rd), .rxf_rdata(rxf_rdata), .rxf_rtag(rxf_rtag),
        .rx_en(rx_en), .tx_en(tx_en), .tx_ser(tx_ser), .rx_line(rx_line),
        .rx_ser(rx_ser)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    typedef struct {
        int          what;
        string       req;
        logic [31:0] exp;
    } item_t;

    item_t sb[$];
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;

    function automatic logic [31:0] pay(logic [DW-1:0] d, logic [TW-1:0] t);
        return 32'({d, t});
    endfunction

    function automatic logic [31:0] observe(int what);
        case (what)
            OB_RDATA:   return 32'(cfg_rdata);
            OB_SRST:    return 32'(soft_rst);
            OB_CRC:     return 32'(crc_test_mode);
            OB_ADDR:    return 32'(addr_test_mode);
            OB_TXF_WR:  return 32'(txf_wr);
            OB_TXF_PAY: return pay(txf_wdata, txf_wtag);
            OB_RXF_WR:  return 32'(rxf_wr);
            OB_RXF_PAY: return pay(rxf_wdata, rxf_wtag);
            OB_RD_SEL:  return 32'({txf_rd, rxf_rd});
            OB_RD_PAY:  return pay(hst_rd_data, hst_rd_tag);
            OB_RXSER:   return 32'(rx_ser);
            default:    return 32'hDEAD_BEEF;
        endcase
    endfunction

    task automatic push(int what, string req, logic [31:0] exp);
        item_t it;
        it.what = what;
        it.req  = req;
        it.exp  = exp;
        sb.push_back(it);
    endtask

    // monitor: compares away from the active edge
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (sb.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it  = sb.pop_front();
                act = observe(it.what);
                n_cmp++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s (probe %0d): actual %h expected %h",
                             it.req, it.what, act, it.exp);
                end
            end
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL R1 watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic cfg_write(logic [7:0] v);
        @(negedge clk);
        cfg_wr    = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_wr    = 1'b0;
        cfg_wdata = 8'h00;
    endtask

    task automatic stim(logic rv, logic [DW-1:0] rd, logic [TW-1:0] rt,
                        logic hw, logic [DW-1:0] hd, logic [TW-1:0] ht,
                        logic hr);
        @(negedge clk);
        rxp_valid    = rv;
        rxp_data     = rd;
        rxp_tag      = rt;
        hst_txf_wr   = hw;
        hst_txf_data = hd;
        hst_txf_tag  = ht;
        hst_rxf_rd   = hr;
    endtask

    task automatic ser(logic re, logic te, logic ts, logic rl);
        @(negedge clk);
        rx_en   = re;
        tx_en   = te;
        tx_ser  = ts;
        rx_line = rl;
    endtask

    initial begin
        rst_n = 1'b0;
        cfg_wr = 1'b0; cfg_wdata = 8'h00;
        rxp_valid = 1'b0; rxp_data = '0; rxp_tag = '0;
        hst_txf_wr = 1'b0; hst_txf_data = '0; hst_txf_tag = '0;
        hst_rxf_rd = 1'b0;
        txf_rdata = 8'hA1; txf_rtag = 2'b10;
        rxf_rdata = 8'hB2; rxf_rtag = 2'b01;
        rx_en = 1'b0; tx_en = 1'b0; tx_ser = 1'b0; rx_line = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        push(OB_RDATA, "R1", 32'h00);
        push(OB_SRST,  "R1", 32'h0);
        push(OB_CRC,   "R1", 32'h0);
        push(OB_ADDR,  "R1", 32'h0);

        // R2 R5 R6: all ones written
        cfg_write(8'hFF);
        push(OB_SRST,  "R2", 32'h1);
        push(OB_RDATA, "R5", 32'hCF);
        push(OB_CRC,   "R6", 32'h1);
        push(OB_ADDR,  "R6", 32'h1);

        // R3: first zero keeps reset, second clears it
        cfg_write(8'h00);
        push(OB_SRST,  "R3", 32'h1);
        push(OB_RDATA, "R3", 32'h80);
        cfg_write(8'h00);
        push(OB_SRST,  "R3", 32'h0);
        push(OB_RDATA, "R3", 32'h00);

        // R4: one-write between zeros restarts the run
        cfg_write(8'h80);
        cfg_write(8'h00);
        push(OB_SRST, "R4", 32'h1);
        cfg_write(8'h80);
        push(OB_SRST, "R4", 32'h1);
        cfg_write(8'h00);
        push(OB_SRST, "R4", 32'h1);
        cfg_write(8'h00);
        push(OB_SRST, "R4", 32'h0);

        // R5 reserved bits alone; R6 single mode bits
        cfg_write(8'h30);
        push(OB_RDATA, "R5", 32'h00);
        cfg_write(8'h08);
        push(OB_CRC,  "R6", 32'h1);
        push(OB_ADDR, "R6", 32'h0);
        cfg_write(8'h02);
        push(OB_CRC,  "R6", 32'h0);
        push(OB_ADDR, "R6", 32'h1);

        // normal routing
        cfg_write(8'h00);
        stim(1'b1, 8'h5A, 2'b01, 1'b0, 8'h00, 2'b00, 1'b0);
        push(OB_RXF_WR,  "R7", 32'h1);
        push(OB_RXF_PAY, "R7", pay(8'h5A, 2'b01));
        push(OB_TXF_WR,  "R7", 32'h0);
        stim(1'b0, 8'h00, 2'b00, 1'b1, 8'h3C, 2'b01, 1'b0);
        push(OB_TXF_WR,  "R8", 32'h1);
        push(OB_TXF_PAY, "R8", pay(8'h3C, 2'b01));
        push(OB_RXF_WR,  "R8", 32'h0);
        stim(1'b0, 8'h00, 2'b00, 1'b0, 8'h00, 2'b00, 1'b1);
        push(OB_RD_SEL, "R10", 32'h1);
        push(OB_RD_PAY, "R10", pay(8'hB2, 2'b01));
        stim(1'b0, 8'h00, 2'b00, 1'b0, 8'h00, 2'b00, 1'b0);

        // receive-to-transmit loopback, bad packet end tag
        cfg_write(8'h40);
        stim(1'b1, 8'hC3, 2'b11, 1'b0, 8'h00, 2'b00, 1'b0);
        push(OB_TXF_WR,  "R7", 32'h1);
        push(OB_TXF_PAY, "R7", pay(8'hC3, 2'b11));
        push(OB_RXF_WR,  "R7", 32'h1);
        push(OB_RXF_PAY, "R7", pay(8'hC3, 2'b11));
        stim(1'b1, 8'h96, 2'b00, 1'b1, 8'h3C, 2'b01, 1'b0);
        push(OB_TXF_WR,  "R8", 32'h1);
        push(OB_TXF_PAY, "R8", pay(8'h96, 2'b00));
        stim(1'b0, 8'h00, 2'b00, 1'b1, 8'h3C, 2'b01, 1'b0);
        push(OB_TXF_PAY, "R8", pay(8'h3C, 2'b01));
        stim(1'b0, 8'h00, 2'b00, 1'b0, 8'h00, 2'b00, 1'b0);

        // FIFO test swap
        cfg_write(8'h04);
        stim(1'b1, 8'h5A, 2'b00, 1'b1, 8'h77, 2'b01, 1'b0);
        push(OB_RXF_WR,  "R9", 32'h1);
        push(OB_RXF_PAY, "R9", pay(8'h77, 2'b01));
        push(OB_TXF_WR,  "R9", 32'h0);
        stim(1'b1, 8'h5A, 2'b00, 1'b0, 8'h00, 2'b00, 1'b0);
        push(OB_RXF_WR,  "R9", 32'h0);
        stim(1'b0, 8'h00, 2'b00, 1'b0, 8'h00, 2'b00, 1'b1);
        push(OB_RD_SEL, "R10", 32'h2);
        push(OB_RD_PAY, "R10", pay(8'hA1, 2'b10));
        stim(1'b0, 8'h00, 2'b00, 1'b0, 8'h00, 2'b00, 1'b0);

        // transmit-to-receive loopback
        cfg_write(8'h01);
        ser(1'b1, 1'b1, 1'b1, 1'b0);
        push(OB_RXSER, "R11", 32'h1);
        ser(1'b1, 1'b1, 1'b0, 1'b1);
        push(OB_RXSER, "R11", 32'h0);
        ser(1'b0, 1'b1, 1'b1, 1'b0);
        push(OB_RXSER, "R11", 32'h0);
        ser(1'b1, 1'b0, 1'b1, 1'b0);
        push(OB_RXSER, "R11", 32'h0);
        cfg_write(8'h00);
        ser(1'b1, 1'b1, 1'b0, 1'b1);
        push(OB_RXSER, "R11", 32'h1);

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule